// File: doc/BRIEF.md
# Two-Channel Serial Audio Receiver with Mono Channel Pick

This block turns a two-channel serial audio stream into parallel mono samples. The stream comes in as three wires: a bit clock, a word clock that marks which channel is being sent, and a data line. All three are brought into the system clock domain, and all framing decisions are made there. A format input picks one of two framings. The first is an I2S-style frame that carries words of 16 to 24 bits. The second is a frame that carries a 16-bit word pushed to the end of each half.

A channel-pick input chooses the left or right word of every frame. Each chosen word is delivered as a 24-bit two's-complement value together with a single-cycle valid strobe, so the block produces at most one output per sample period. A small state machine tracks each half-frame:

- `ST_HUNT` is entered at reset and waits for the first word-clock transition after the bit clock starts. Transition T1 (`ST_HUNT`→`ST_FILL`) fires on that first transition and produces no output.
- In `ST_FILL` the block collects word bits.
- Transition T2 (`ST_FILL`→`ST_PAD`) fires, in the I2S framing only, once 24 bits have been collected. `ST_PAD` then ignores the rest of the slot.
- Transitions T3 (`ST_FILL`→`ST_FILL`) and T4 (`ST_PAD`→`ST_FILL`) fire on each later word-clock transition. Each one closes the word of the half that just ended, outputs it if it belongs to the chosen channel, and starts the next half.

Top module: `aud_ser_rx`

## Requirements
- R1: While reset is asserted, and after it is released until the first word is emitted, `sample_vld_o` is 0 and `sample_o` is 0.
- R2: The data line is sampled at each rising edge of the bit clock. Words are two's complement and arrive MSB first.
- R3: With `fmt_rj_i` = 0 (I2S framing), the MSB of a word comes on the second rising bit-clock edge after a word-clock transition. The word-clock-low half carries the left word and the high half carries the right word.
- R4: In I2S framing, a word of N bits (16 ≤ N ≤ 24) is output left-aligned: `sample_o[23:24-N]` holds the word and the lower bits are 0. The sender drives 0 after the LSB. Slot bits after the 24th word bit are ignored.
- R5: I2S framing works with 24 or 32 bit clocks per half (48 or 64 per sample). This includes a 24-bit word at 48 per sample, where the LSB lands on the first bit clock of the following half.
- R6: With `fmt_rj_i` = 1, the word is the 16 bits whose LSB is on the last rising bit-clock edge before the word-clock transition. Earlier bits of the slot are ignored. The word-clock-high half carries the left word.
- R7: In right-justified framing, `sample_o` = {8 copies of word bit 15, word[15:0]}.
- R8: Right-justified framing works with 16, 24 or 32 bit clocks per half (32, 48 or 64 per sample).
- R9: With `sel_left_i` = 1 only left words are output, and with 0 only right words, one per frame in arrival order. Left comes before right in each frame.
- R10: `sample_vld_o` is high for exactly one system clock per emitted word. No word is output for the half during which the first word-clock transition is being hunted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| wclk_i | input | 1 | Serial word clock (asynchronous) |
| sdat_i | input | 1 | Serial data line (asynchronous) |
| fmt_rj_i | input | 1 | 0: I2S 16–24 bit, 1: 16-bit right-justified |
| sel_left_i | input | 1 | 1: output left word, 0: output right word |
| sample_o | output | 24 | Selected sample, two's complement |
| sample_vld_o | output | 1 | One-cycle strobe marking a new `sample_o` |

## Verification
The bench checks each framing with every bit-clock ratio it allows and with both channel picks. For each run it computes the expected samples from extreme words (largest positive, most negative, zero, all ones) and from arithmetic patterns. If the MSB offset were wrong by one, every I2S sample would come out doubled or halved. If the next-half LSB were dropped, the 24-bit word at 48 per sample would lose bit 0. If the right-justified window were misplaced, the leading padding ones would leak into the sample. A channel polarity error would output the other channel's words. If the first-transition handling were wrong, there would be a spurious or a missing first word, and the per-run word count catches that.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_FILL = 2'd1,
        ST_PAD  = 2'd2
    } rx_state_t;

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d_i[b]};
        end
        assign q_o[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/aud_rx_bitclk.sv
module aud_rx_bitclk (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_s_i,
    input  logic wclk_s_i,
    input  logic data_s_i,
    output logic bit_stb_o,
    output logic slot_start_o,
    output logic bit_o,
    output logic prev_wclk_o
);

    logic bclk_d;
    logic wclk_last;
    logic primed;

    assign bit_stb_o    = bclk_s_i & ~bclk_d;
    assign slot_start_o = bit_stb_o & primed & (wclk_s_i != wclk_last);
    assign bit_o        = data_s_i;
    assign prev_wclk_o  = wclk_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_d    <= 1'b0;
            wclk_last <= 1'b0;
            primed    <= 1'b0;
        end else begin
            bclk_d <= bclk_s_i;
            if (bit_stb_o) begin
                wclk_last <= wclk_s_i;
                primed    <= 1'b1;
            end
        end
    end

    // R2: one captured bit per bit-clock rise, never two cycles in a row
    a_r2_stb_gap: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb_o |=> !bit_stb_o);

endmodule

// File: rtl/aud_rx_frame_fsm.sv
module aud_rx_frame_fsm
    import aud_rx_pkg::*;
#(
    parameter int OUT_W = 24,
    parameter int RJ_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb_i,
    input  logic             slot_start_i,
    input  logic             bit_i,
    input  logic             prev_wclk_i,
    input  logic             fmt_rj_i,
    input  logic             sel_left_i,
    output logic [OUT_W-1:0] sample_o,
    output logic             vld_o
);

    localparam int CNT_W = $clog2(OUT_W + 1);

    rx_state_t        state, state_nx;
    logic [OUT_W-1:0] acc;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] sh;
    logic [OUT_W-1:0] ins_word;
    logic [OUT_W-1:0] i2s_word;
    logic [OUT_W-1:0] rj_word;
    logic             half_left;
    logic             emit;

    assign sh        = CNT_W'(OUT_W - 1) - cnt;
    assign ins_word  = acc | (OUT_W'(bit_i) << sh);
    assign i2s_word  = (state == ST_FILL) ? ins_word : acc;
    assign rj_word   = {{(OUT_W-RJ_W){acc[RJ_W-1]}}, acc[RJ_W-1:0]};
    assign half_left = fmt_rj_i ? prev_wclk_i : ~prev_wclk_i;
    assign emit      = slot_start_i && (state != ST_HUNT)
                    && (fmt_rj_i ? (cnt >= CNT_W'(RJ_W)) : 1'b1)
                    && (half_left == sel_left_i);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    // transitions T1..T4
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT: if (slot_start_i) state_nx = ST_FILL;
            ST_FILL: begin
                if (slot_start_i)
                    state_nx = ST_FILL;
                else if (bit_stb_i && !fmt_rj_i && cnt == CNT_W'(OUT_W - 1))
                    state_nx = ST_PAD;
            end
            ST_PAD:  if (slot_start_i) state_nx = ST_FILL;
            default: state_nx = ST_HUNT;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc      <= '0;
            cnt      <= '0;
            sample_o <= '0;
            vld_o    <= 1'b0;
        end else begin
            vld_o <= 1'b0;
            if (slot_start_i) begin
                if (emit) begin
                    sample_o <= fmt_rj_i ? rj_word : i2s_word;
                    vld_o    <= 1'b1;
                end
                acc <= fmt_rj_i ? OUT_W'(bit_i) : '0;
                cnt <= fmt_rj_i ? CNT_W'(1) : '0;
            end else if (bit_stb_i && state != ST_HUNT) begin
                if (fmt_rj_i) begin
                    acc <= {acc[OUT_W-2:0], bit_i};
                    if (cnt != CNT_W'(OUT_W)) cnt <= cnt + 1'b1;
                end else if (state == ST_FILL) begin
                    acc <= ins_word;
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R10: the strobe lasts one system clock
    a_r10_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> !vld_o);

    // R10: nothing leaves while the first word-clock transition is hunted
    a_r10_hunt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT) |=> !vld_o);

    // R4: the bit count never passes the output width
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(OUT_W));

    // R7: a right-justified sample carries a clean sign extension
    a_r7_rj_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && $past(fmt_rj_i)) |->
        ((&sample_o[OUT_W-1:RJ_W-1]) || !(|sample_o[OUT_W-1:RJ_W-1])));

endmodule

// File: rtl/aud_ser_rx.sv
module aud_ser_rx #(
    parameter int OUT_W       = 24,
    parameter int RJ_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_i,
    input  logic             wclk_i,
    input  logic             sdat_i,
    input  logic             fmt_rj_i,
    input  logic             sel_left_i,
    output logic [OUT_W-1:0] sample_o,
    output logic             sample_vld_o
);

    logic [2:0] raw;
    logic [2:0] syn;
    logic       bit_stb;
    logic       slot_start;
    logic       bit_v;
    logic       prev_wclk;

    assign raw = {sdat_i, wclk_i, bclk_i};

    aud_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (syn)
    );

    aud_rx_bitclk u_bitclk (
        .clk          (clk),
        .rst_n        (rst_n),
        .bclk_s_i     (syn[0]),
        .wclk_s_i     (syn[1]),
        .data_s_i     (syn[2]),
        .bit_stb_o    (bit_stb),
        .slot_start_o (slot_start),
        .bit_o        (bit_v),
        .prev_wclk_o  (prev_wclk)
    );

    aud_rx_frame_fsm #(.OUT_W(OUT_W), .RJ_W(RJ_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_stb_i    (bit_stb),
        .slot_start_i (slot_start),
        .bit_i        (bit_v),
        .prev_wclk_i  (prev_wclk),
        .fmt_rj_i     (fmt_rj_i),
        .sel_left_i   (sel_left_i),
        .sample_o     (sample_o),
        .vld_o        (sample_vld_o)
    );

endmodule

// File: tb/tb_aud_ser_rx.sv
`timescale 1ns/1ps
module tb_aud_ser_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        wclk = 1'b0;
    logic        sdat = 1'b0;
    logic        fmt_rj = 1'b0;
    logic        sel_left = 1'b0;
    logic [23:0] sample;
    logic        vld;

    int n_chk = 0;
    int n_bad = 0;
    logic [23:0] got_q[$];

    always #2.5 clk = ~clk;

    aud_ser_rx dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bclk_i       (bclk),
        .wclk_i       (wclk),
        .sdat_i       (sdat),
        .fmt_rj_i     (fmt_rj),
        .sel_left_i   (sel_left),
        .sample_o     (sample),
        .sample_vld_o (vld)
    );

    always @(negedge clk) if (rst_n && vld) got_q.push_back(sample);

    task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bit(logic w, logic d);
        bclk = 1'b0; wclk = w; sdat = d;
        repeat (4) @(negedge clk);
        bclk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [23:0] gen_word(int g, int i, int len);
        logic [23:0] m = 24'((64'd1 << len) - 1);
        case (i)
            0: return m >> 1;
            1: return 24'(1 << (len - 1));
            2: return 24'd0;
            3: return m;
            default: return 24'(g * 40503 + i * 2654435 + 12345) & m;
        endcase
    endfunction

    function automatic logic i2s_bit(logic [23:0] w, int len, int k);
        return (k < len) ? w[len-1-k] : 1'b0;
    endfunction

    function automatic logic rj_bit(logic [23:0] w, int p, int s);
        int k = p - (s - 16);
        return (k < 0) ? 1'b1 : w[15-k];
    endfunction

    function automatic logic [23:0] expect_of(logic rj, logic [23:0] w, int len);
        if (rj) return {{8{w[15]}}, w[15:0]};
        return w << (24 - len);
    endfunction

    task automatic run_group(logic rj, int ratio, int len, logic sel, int g);
        int s = ratio / 2;
        int nfr = 6;
        logic left_lvl = rj;
        logic [23:0] wl[6];
        logic [23:0] wr[6];
        logic [23:0] prev = '0;
        string tag;
        fmt_rj = rj; sel_left = sel; bclk = 1'b0; wclk = ~left_lvl; sdat = 1'b0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 reset vld", {23'd0, vld}, 24'd0);
        chk("R1 reset sample", sample, 24'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        got_q.delete();
        for (int i = 0; i < nfr; i++) begin
            wl[i] = gen_word(g, 2*i, len);
            wr[i] = gen_word(g + 7, 2*i + 1, len);
        end
        for (int p = 0; p < s; p++) send_bit(~left_lvl, 1'b0);
        chk("R1 no word before first half", 24'(got_q.size()), 24'd0);
        for (int i = 0; i < nfr; i++) begin
            for (int h = 0; h < 2; h++) begin
                logic [23:0] w = h ? wr[i] : wl[i];
                logic lvl = h ? ~left_lvl : left_lvl;
                for (int p = 0; p < s; p++) begin
                    logic d;
                    if (rj)          d = rj_bit(w, p, s);
                    else if (p == 0) d = i2s_bit(prev, len, s - 1);
                    else             d = i2s_bit(w, len, p - 1);
                    send_bit(lvl, d);
                end
                prev = w;
            end
        end
        send_bit(left_lvl, rj ? 1'b1 : i2s_bit(prev, len, s - 1));
        repeat (12) @(negedge clk);
        if (rj) tag = $sformatf("R6 R7 R8 ratio %0d sel %0d R9", ratio, sel);
        else if (len == 24) tag = $sformatf("R2 R3 R5 ratio %0d sel %0d R9", ratio, sel);
        else tag = $sformatf("R3 R4 len %0d ratio %0d sel %0d R9", len, ratio, sel);
        chk({"R10 word count ", tag}, 24'(got_q.size()), 24'(nfr));
        for (int i = 0; i < nfr && i < got_q.size(); i++)
            chk(tag, got_q[i], expect_of(rj, sel ? wl[i] : wr[i], len));
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int g = 1;
        for (int si = 0; si < 2; si++) begin
            for (int r = 32; r <= 64; r += 16) begin
                run_group(1'b1, r, 16, si[0], g);
                g++;
            end
            for (int r = 48; r <= 64; r += 16) begin
                for (int len = 16; len <= 24; len += 4) begin
                    run_group(1'b0, r, len, si[0], g);
                    g++;
                end
            end
        end
        report();
    end

endmodule